// File: doc/BRIEF.md
# Reset and Boot Sequencer

This block decides when a microcontroller-style system may leave reset and how it starts. A power-on reset (`rst`) runs the whole sequence: a supply settle wait, then a clock-enable wait, then a handshake with the flash controller. An assertion of the external reset pin later in operation skips the settle wait and re-enters at the clock-enable step. Internal reset stays high after the pin is released and is only dropped once the flash controller reports that its initialization is done. At that point the pin is sampled again, and if it still reads low the system waits until it reads high.

When internal reset deasserts, the block latches three things. It latches the boot mode: serial programming when the synchronized chip-select strap is low and the disable option is clear, normal boot otherwise. It latches the slow-clock select from the low-power-boot option. It also loads the link register with all ones. In normal boot it fetches two vector words over a valid/ready read port: the stack pointer from offset 0 and the program counter from offset 4. It then raises the core-run enable. In programming boot it makes no fetch and raises a programming-active output. A nonvolatile-data ready flag stays low until the flash controller reports that its restore has finished.

Top module: `boot_seq_top`

## Requirements
- R1: Internal reset (`sys_rst`) stays high after the pin is released until `flash_init_done` is seen while `flash_init_req` is high. `flash_init_req` is high only while the block waits for that report.
- R2: If the synchronized pin reads low when flash initialization completes, `sys_rst` stays high and `flash_init_req` goes low. Release follows once the pin reads high.
- R3: `prog_mode` is set to 1 when the synchronized strap `prog_cs_n` is 0 in the cycle that `sys_rst` falls, and to 0 otherwise. Strap changes after release leave it unchanged until the next release.
- R4: With `opt_prog_dis` = 1, release always gives `prog_mode` = 0 and a normal boot, whatever the strap level.
- R5: `slow_clk_sel` takes the value of `opt_lpboot` at release and returns to 0 when a later reset starts.
- R6: In normal boot the block requests address `VEC_BASE` and then `VEC_BASE`+4. A request holds its address until `vec_req_ready` is high. The first `vec_rsp_data` word returned while `vec_rsp_valid` is high becomes `core_sp`, and the second becomes `core_pc`. Responses with no outstanding request are ignored.
- R7: `core_lr` is 0 during reset and 0xFFFF_FFFF from the release cycle on.
- R8: `nv_ready` is 0 while `sys_rst` is high and after release until `nv_restore_done` is seen high. After that it stays 1 until the next reset.
- R9: After `rst` falls, `flash_init_req` rises on the (PWRUP_CYC+CLKEN_CYC)th clock edge. After an external pin assertion during operation, it rises on the (CLKEN_CYC+3)th edge.
- R10: The pin and the strap each pass through a two-flop synchronizer. A pin assertion during operation raises `sys_rst` on the third clock edge after it.
- R11: `core_run` is 0 through reset and the vector fetch. It rises one clock edge after the edge that takes in the second word.
- R12: In programming boot, `prog_active` is 1, `core_run` stays 0 and no read request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; starts the full sequence |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| prog_cs_n | input | 1 | Programming chip-select strap, low selects programming boot |
| opt_prog_dis | input | 1 | Option bit: 1 forces normal boot |
| opt_lpboot | input | 1 | Option bit: 1 selects the slow clock at release |
| flash_init_done | input | 1 | Flash controller reports that initialization is done |
| nv_restore_done | input | 1 | Flash controller reports that the nonvolatile restore is done |
| flash_init_req | output | 1 | Block is waiting for flash initialization |
| vec_req_valid | output | 1 | Vector read request valid |
| vec_req_addr | output | ADDR_W | Vector read address |
| vec_req_ready | input | 1 | Memory accepts the request |
| vec_rsp_valid | input | 1 | Read data valid |
| vec_rsp_data | input | DATA_W | Read data |
| sys_rst | output | 1 | Internal system reset, active high |
| slow_clk_sel | output | 1 | Slow clock select |
| prog_mode | output | 1 | Latched boot mode, 1 = programming |
| prog_active | output | 1 | Programming boot is running |
| core_run | output | 1 | Core may execute |
| core_sp | output | DATA_W | Initial stack pointer |
| core_pc | output | DATA_W | Initial program counter |
| core_lr | output | DATA_W | Initial link register |
| nv_ready | output | 1 | Nonvolatile data is available |

## Verification
The hardest case to reach from the ports is a release made from the hold state. It needs flash initialization to finish while the synchronized pin is still low. The stimulus therefore keeps the pin low for a long time after a later reset, lets the flash responder report done, checks that internal reset holds, and only then lets the pin go. A second hard case is a pin assertion that arrives during the vector fetch. The bench waits for the first request to appear and then pulls the pin low again, so the fetch is abandoned and repeated from the start. The memory responder stalls `vec_req_ready` in a fixed pattern and sends stray responses while no request is outstanding, so the ignore rule is exercised as well.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

  // Sequencer phases; the order of the first three follows the reset flow.
  typedef enum logic [2:0] {
    BS_PWRUP,
    BS_CLKEN,
    BS_FLASH,
    BS_HOLD,
    BS_FETCH,
    BS_RUN,
    BS_PROG
  } boot_state_e;

  // Vector fetch engine phases.
  typedef enum logic [2:0] {
    VF_IDLE,
    VF_REQ_SP,
    VF_WAIT_SP,
    VF_REQ_PC,
    VF_WAIT_PC,
    VF_DONE
  } fetch_state_e;

  function automatic logic is_live(boot_state_e s);
    return (s == BS_FETCH) || (s == BS_RUN) || (s == BS_PROG);
  endfunction

endpackage

// File: rtl/boot_sync.sv
`timescale 1ns/1ps
module boot_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/boot_vec_fetch.sv
`timescale 1ns/1ps
module boot_vec_fetch
  import boot_seq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] SP_ADDR = VEC_BASE;
  localparam logic [ADDR_W-1:0] PC_ADDR = VEC_BASE + ADDR_W'(4);

  fetch_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= VF_IDLE;
      sp <= '0;
      pc <= '0;
    end else if (!go) begin
      st <= VF_IDLE;
    end else begin
      unique case (st)
        VF_IDLE: begin
          st <= VF_REQ_SP;
          sp <= '0;
          pc <= '0;
        end
        VF_REQ_SP:  if (req_ready) st <= VF_WAIT_SP;
        VF_WAIT_SP: if (rsp_valid) begin
          sp <= rsp_data;
          st <= VF_REQ_PC;
        end
        VF_REQ_PC:  if (req_ready) st <= VF_WAIT_PC;
        VF_WAIT_PC: if (rsp_valid) begin
          pc <= rsp_data;
          st <= VF_DONE;
        end
        VF_DONE:    st <= VF_DONE;
        default:    st <= VF_IDLE;
      endcase
    end
  end

  assign req_valid = go && ((st == VF_REQ_SP) || (st == VF_REQ_PC));
  assign req_addr  = (st == VF_REQ_PC) ? PC_ADDR : SP_ADDR;
  assign done      = (st == VF_DONE);

endmodule

// File: rtl/boot_fsm.sv
`timescale 1ns/1ps
module boot_fsm
  import boot_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 8,
  parameter int CLKEN_CYC = 4,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_s,
  input  logic              cs_s,
  input  logic              opt_prog_dis,
  input  logic              opt_lpboot,
  input  logic              flash_init_done,
  input  logic              nv_restore_done,
  input  logic              fetch_done,
  output logic              fetch_go,
  output logic              sys_rst,
  output logic              flash_init_req,
  output logic              slow_clk_sel,
  output logic              prog_mode,
  output logic              prog_active,
  output logic              core_run,
  output logic              nv_ready,
  output logic [DATA_W-1:0] core_lr
);

  localparam int MAX_CYC = (PWRUP_CYC > CLKEN_CYC) ? PWRUP_CYC : CLKEN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PWRUP_LAST = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] CLKEN_LAST = CNT_W'(CLKEN_CYC - 1);

  boot_state_e      st, nxt;
  logic [CNT_W-1:0] cnt;
  logic             boot_prog;
  logic             release_now;
  logic             reenter_now;

  assign boot_prog = !opt_prog_dis && !cs_s;

  always_comb begin
    nxt = st;
    unique case (st)
      BS_PWRUP: if (cnt == PWRUP_LAST) nxt = BS_CLKEN;
      BS_CLKEN: if (cnt == CLKEN_LAST) nxt = BS_FLASH;
      BS_FLASH: if (flash_init_done) begin
        if (pin_s) nxt = boot_prog ? BS_PROG : BS_FETCH;
        else       nxt = BS_HOLD;
      end
      BS_HOLD:  if (pin_s) nxt = boot_prog ? BS_PROG : BS_FETCH;
      BS_FETCH: begin
        if (!pin_s)          nxt = BS_CLKEN;
        else if (fetch_done) nxt = BS_RUN;
      end
      BS_RUN:   if (!pin_s) nxt = BS_CLKEN;
      BS_PROG:  if (!pin_s) nxt = BS_CLKEN;
      default:  nxt = BS_PWRUP;
    endcase
  end

  assign release_now = !is_live(st) && is_live(nxt);
  assign reenter_now = is_live(st) && !is_live(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= BS_PWRUP;
      cnt            <= '0;
      sys_rst        <= 1'b1;
      flash_init_req <= 1'b0;
      slow_clk_sel   <= 1'b0;
      prog_mode      <= 1'b0;
      prog_active    <= 1'b0;
      core_run       <= 1'b0;
      nv_ready       <= 1'b0;
      core_lr        <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) begin
        cnt <= '0;
      end else if (st == BS_PWRUP || st == BS_CLKEN) begin
        cnt <= cnt + CNT_W'(1);
      end
      sys_rst        <= !is_live(nxt);
      flash_init_req <= (nxt == BS_FLASH);
      prog_active    <= (nxt == BS_PROG);
      core_run       <= (nxt == BS_RUN);
      if (!is_live(nxt)) begin
        nv_ready <= 1'b0;
      end else if (nv_restore_done) begin
        nv_ready <= 1'b1;
      end
      if (release_now) begin
        prog_mode    <= boot_prog;
        slow_clk_sel <= opt_lpboot;
        core_lr      <= '1;
      end else if (reenter_now) begin
        slow_clk_sel <= 1'b0;
        core_lr      <= '0;
      end
    end
  end

  assign fetch_go = (st == BS_FETCH);

endmodule

// File: rtl/boot_seq_top.sv
`timescale 1ns/1ps
module boot_seq_top #(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE    = '0,
  parameter int                PWRUP_CYC   = 8,
  parameter int                CLKEN_CYC   = 4,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rst_n,
  input  logic              prog_cs_n,
  input  logic              opt_prog_dis,
  input  logic              opt_lpboot,
  input  logic              flash_init_done,
  input  logic              nv_restore_done,
  output logic              flash_init_req,
  output logic              vec_req_valid,
  output logic [ADDR_W-1:0] vec_req_addr,
  input  logic              vec_req_ready,
  input  logic              vec_rsp_valid,
  input  logic [DATA_W-1:0] vec_rsp_data,
  output logic              sys_rst,
  output logic              slow_clk_sel,
  output logic              prog_mode,
  output logic              prog_active,
  output logic              core_run,
  output logic [DATA_W-1:0] core_sp,
  output logic [DATA_W-1:0] core_pc,
  output logic [DATA_W-1:0] core_lr,
  output logic              nv_ready
);

  logic pin_s;
  logic cs_s;
  logic fetch_go;
  logic fetch_done;

  // Bit 1 = strap (idles high), bit 0 = pin (treated as asserted until seen).
  boot_sync #(
    .W       (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({prog_cs_n, ext_rst_n}),
    .q   ({cs_s, pin_s})
  );

  boot_fsm #(
    .PWRUP_CYC (PWRUP_CYC),
    .CLKEN_CYC (CLKEN_CYC),
    .DATA_W    (DATA_W)
  ) u_fsm (
    .clk             (clk),
    .rst             (rst),
    .pin_s           (pin_s),
    .cs_s            (cs_s),
    .opt_prog_dis    (opt_prog_dis),
    .opt_lpboot      (opt_lpboot),
    .flash_init_done (flash_init_done),
    .nv_restore_done (nv_restore_done),
    .fetch_done      (fetch_done),
    .fetch_go        (fetch_go),
    .sys_rst         (sys_rst),
    .flash_init_req  (flash_init_req),
    .slow_clk_sel    (slow_clk_sel),
    .prog_mode       (prog_mode),
    .prog_active     (prog_active),
    .core_run        (core_run),
    .nv_ready        (nv_ready),
    .core_lr         (core_lr)
  );

  boot_vec_fetch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VEC_BASE (VEC_BASE)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .go        (fetch_go),
    .req_valid (vec_req_valid),
    .req_addr  (vec_req_addr),
    .req_ready (vec_req_ready),
    .rsp_valid (vec_rsp_valid),
    .rsp_data  (vec_rsp_data),
    .done      (fetch_done),
    .sp        (core_sp),
    .pc        (core_pc)
  );

endmodule

// File: rtl/boot_seq_chk.sv
`timescale 1ns/1ps
module boot_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pin_s,
  input logic              opt_lpboot,
  input logic              flash_init_req,
  input logic              flash_init_done,
  input logic              sys_rst,
  input logic              slow_clk_sel,
  input logic              prog_mode,
  input logic              prog_active,
  input logic              core_run,
  input logic              nv_ready,
  input logic [DATA_W-1:0] core_lr,
  input logic              vec_req_valid,
  input logic              vec_req_ready,
  input logic [ADDR_W-1:0] vec_req_addr
);

  logic flash_seen;

  always_ff @(posedge clk) begin
    if (rst)                                      flash_seen <= 1'b0;
    else if (!sys_rst)                            flash_seen <= 1'b0;
    else if (flash_init_req && flash_init_done)   flash_seen <= 1'b1;
  end

  p_release_after_flash_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> ($past(flash_seen) || $past(flash_init_req && flash_init_done)));

  p_release_pin_high_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> $past(pin_s));

  p_mode_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst && !$past(sys_rst)) |-> $stable(prog_mode));

  p_slow_at_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> (slow_clk_sel == $past(opt_lpboot)));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst || sys_rst)
    (vec_req_valid && !vec_req_ready) |=> (vec_req_valid && $stable(vec_req_addr)));

  p_lr_ones_r7: assert property (@(posedge clk) disable iff (rst)
    !sys_rst |-> (core_lr == {DATA_W{1'b1}}));

  p_nv_low_in_reset_r8: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> !nv_ready);

  p_reentry_by_pin_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst) |-> !$past(pin_s));

  p_no_run_in_fetch_r11: assert property (@(posedge clk) disable iff (rst)
    vec_req_valid |-> (!core_run && !sys_rst));

  p_prog_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    prog_active |-> (!vec_req_valid && !core_run && prog_mode));

endmodule

bind boot_seq_top boot_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .pin_s           (pin_s),
  .opt_lpboot      (opt_lpboot),
  .flash_init_req  (flash_init_req),
  .flash_init_done (flash_init_done),
  .sys_rst         (sys_rst),
  .slow_clk_sel    (slow_clk_sel),
  .prog_mode       (prog_mode),
  .prog_active     (prog_active),
  .core_run        (core_run),
  .nv_ready        (nv_ready),
  .core_lr         (core_lr),
  .vec_req_valid   (vec_req_valid),
  .vec_req_ready   (vec_req_ready),
  .vec_req_addr    (vec_req_addr)
);

// File: tb/tb_boot_seq_top.sv
`timescale 1ns/1ps
module tb_boot_seq_top;

  localparam int PWRUP  = 8;
  localparam int CLKEN  = 4;
  localparam int FL_LAT = 4;
  localparam int RSP_LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_rst_n = 1'b0;
  logic        prog_cs_n = 1'b1;
  logic        opt_prog_dis = 1'b0;
  logic        opt_lpboot = 1'b0;
  logic        flash_init_done = 1'b0;
  logic        nv_restore_done = 1'b0;
  logic        flash_init_req;
  logic        vec_req_valid;
  logic [31:0] vec_req_addr;
  logic        vec_req_ready = 1'b0;
  logic        vec_rsp_valid = 1'b0;
  logic [31:0] vec_rsp_data = '0;
  logic        sys_rst, slow_clk_sel, prog_mode, prog_active, core_run, nv_ready;
  logic [31:0] core_sp, core_pc, core_lr;

  always #5 clk = ~clk;

  boot_seq_top #(.PWRUP_CYC(PWRUP), .CLKEN_CYC(CLKEN)) dut (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .prog_cs_n(prog_cs_n),
    .opt_prog_dis(opt_prog_dis), .opt_lpboot(opt_lpboot),
    .flash_init_done(flash_init_done), .nv_restore_done(nv_restore_done),
    .flash_init_req(flash_init_req), .vec_req_valid(vec_req_valid),
    .vec_req_addr(vec_req_addr), .vec_req_ready(vec_req_ready),
    .vec_rsp_valid(vec_rsp_valid), .vec_rsp_data(vec_rsp_data),
    .sys_rst(sys_rst), .slow_clk_sel(slow_clk_sel), .prog_mode(prog_mode),
    .prog_active(prog_active), .core_run(core_run), .core_sp(core_sp),
    .core_pc(core_pc), .core_lr(core_lr), .nv_ready(nv_ready)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 settle, 1 clock enable, 2 flash wait, 3 pin hold, 4 fetch, 5 run, 6 programming
  int          mph, mcnt, mf;
  int          mp1, mp2, mc1, mc2;
  logic [31:0] msp, mpc;
  logic        m_sys, m_flash, m_slow, m_pm, m_pa, m_run, m_nv, m_lr;

  always @(posedge clk) begin
    int  nph, nf;
    bit  bp, live_now, live_nxt;
    if (rst) begin
      mph = 0; mcnt = 0; mf = 0; mp1 = 0; mp2 = 0; mc1 = 1; mc2 = 1;
      msp = 0; mpc = 0; m_sys = 1; m_flash = 0; m_slow = 0; m_pm = 0;
      m_pa = 0; m_run = 0; m_nv = 0; m_lr = 0;
    end else begin
      bp  = !opt_prog_dis && (mc2 == 0);
      nph = mph;
      case (mph)
        0: if (mcnt == PWRUP - 1) nph = 1;
        1: if (mcnt == CLKEN - 1) nph = 2;
        2: if (flash_init_done) nph = (mp2 != 0) ? (bp ? 6 : 4) : 3;
        3: if (mp2 != 0) nph = bp ? 6 : 4;
        4: if (mp2 == 0) nph = 1; else if (mf == 5) nph = 5;
        default: if (mp2 == 0) nph = 1;
      endcase
      nf = mf;
      if (mph != 4) nf = 0;
      else case (mf)
        0: begin nf = 1; msp = 0; mpc = 0; end
        1: if (vec_req_ready) nf = 2;
        2: if (vec_rsp_valid) begin msp = vec_rsp_data; nf = 3; end
        3: if (vec_req_ready) nf = 4;
        4: if (vec_rsp_valid) begin mpc = vec_rsp_data; nf = 5; end
        default: nf = 5;
      endcase
      live_now = (mph >= 4);
      live_nxt = (nph >= 4);
      if (nph != mph) mcnt = 0;
      else if (mph <= 1) mcnt++;
      m_sys   = !live_nxt;
      m_flash = (nph == 2);
      m_pa    = (nph == 6);
      m_run   = (nph == 5);
      m_nv    = live_nxt ? (m_nv || nv_restore_done) : 1'b0;
      if (!live_now && live_nxt) begin m_pm = bp; m_slow = opt_lpboot; m_lr = 1; end
      else if (live_now && !live_nxt) begin m_slow = 0; m_lr = 0; end
      mph = nph; mf = nf;
      mp2 = mp1; mp1 = ext_rst_n;
      mc2 = mc1; mc1 = prog_cs_n;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    logic mval;
    if (!rst) begin
      mval = ((mf == 1) || (mf == 3)) && (mph == 4);
      chk("R1", "sys_rst", sys_rst, m_sys);
      chk("R9", "flash_init_req", flash_init_req, m_flash);
      chk("R5", "slow_clk_sel", slow_clk_sel, m_slow);
      chk("R3", "prog_mode", prog_mode, m_pm);
      chk("R12", "prog_active", prog_active, m_pa);
      chk("R11", "core_run", core_run, m_run);
      chk("R8", "nv_ready", nv_ready, m_nv);
      chk("R7", "core_lr", core_lr, m_lr ? 32'hFFFF_FFFF : 32'h0);
      chk("R6", "vec_req_valid", vec_req_valid, mval);
      if (mval) chk("R6", "vec_req_addr", vec_req_addr, (mf == 3) ? 32'd4 : 32'd0);
      chk("R6", "core_sp", core_sp, msp);
      chk("R6", "core_pc", core_pc, mpc);
    end
  end

  // ---------------- flash controller and memory responders ----------------
  int fcnt = 0;
  always @(negedge clk) begin
    if (rst || !flash_init_req) begin
      fcnt = 0;
      flash_init_done = 1'b0;
    end else begin
      fcnt++;
      flash_init_done = (fcnt >= FL_LAT);
    end
  end

  logic [31:0] sp_word = 32'h2000_1000;
  logic [31:0] pc_word = 32'h0000_0401;
  int          tick = 0, pend_cnt = 0;
  logic [31:0] pend_data = '0;
  logic        prev_acc = 1'b0;
  logic [31:0] prev_addr = '0;

  always @(negedge clk) begin
    bit fired;
    tick++;
    fired = 0;
    vec_rsp_valid = 1'b0;
    if (rst) begin
      pend_cnt = 0; prev_acc = 0; vec_req_ready = 1'b0;
    end else begin
      if (prev_acc) begin
        pend_data = (prev_addr == 32'd4) ? pc_word : sp_word;
        pend_cnt  = RSP_LAT;
      end
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          vec_rsp_valid = 1'b1; vec_rsp_data = pend_data; fired = 1;
        end
      end
      if (!fired && pend_cnt == 0 && (tick % 7) == 3) begin
        vec_rsp_valid = 1'b1; vec_rsp_data = 32'hDEAD_BEEF;  // stray response
      end
      vec_req_ready = ((tick % 3) != 1);
      prev_acc  = vec_req_valid && vec_req_ready;
      prev_addr = vec_req_addr;
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- directed scenarios ----------------
  initial begin
    int n;
    int reqs;
    cyc(3);
    // Reset state
    chk("R1", "reset sys_rst", sys_rst, 1'b1);
    chk("R11", "reset core_run", core_run, 1'b0);
    chk("R7", "reset core_lr", core_lr, 32'h0);
    chk("R8", "reset nv_ready", nv_ready, 1'b0);

    // Scenario 1: power-on boot, normal mode
    rst = 1'b0; ext_rst_n = 1'b1;
    n = 0;
    while (!flash_init_req) begin @(negedge clk); n++; end
    chk("R9", "first-reset edges to flash request", n, PWRUP + CLKEN);
    chk("R1", "held while flash busy, pin high", sys_rst, 1'b1);
    while (!core_run) @(negedge clk);
    chk("R6", "stack pointer", core_sp, 32'h2000_1000);
    chk("R6", "program counter", core_pc, 32'h0000_0401);
    chk("R7", "link register", core_lr, 32'hFFFF_FFFF);
    chk("R3", "normal mode latched", prog_mode, 1'b0);
    chk("R5", "no slow clock", slow_clk_sel, 1'b0);
    chk("R8", "nv_ready before restore", nv_ready, 1'b0);
    nv_restore_done = 1'b1; cyc(2);
    chk("R8", "nv_ready after restore", nv_ready, 1'b1);
    nv_restore_done = 1'b0; cyc(2);
    chk("R8", "nv_ready sticky", nv_ready, 1'b1);
    prog_cs_n = 1'b0; cyc(6);
    chk("R3", "strap after release ignored", prog_mode, 1'b0);
    chk("R3", "core keeps running", core_run, 1'b1);

    // Scenario 2: later reset, pin held low past flash done, low-power boot
    prog_cs_n = 1'b1; opt_lpboot = 1'b1;
    sp_word = 32'h1FFF_8000; pc_word = 32'h0000_1235;
    ext_rst_n = 1'b0;
    n = 0;
    while (!sys_rst) begin @(negedge clk); n++; end
    chk("R10", "edges from pin to sys_rst", n, 3);
    chk("R5", "slow cleared on reset", slow_clk_sel, 1'b0);
    chk("R8", "nv_ready cleared on reset", nv_ready, 1'b0);
    while (!flash_init_req) begin @(negedge clk); n++; end
    chk("R9", "later-reset edges to flash request", n, CLKEN + 3);
    cyc(25);
    chk("R2", "held with pin low after flash done", sys_rst, 1'b1);
    chk("R2", "flash request dropped in hold", flash_init_req, 1'b0);
    ext_rst_n = 1'b1;
    while (sys_rst) @(negedge clk);
    chk("R5", "slow clock at release", slow_clk_sel, 1'b1);
    while (!core_run) @(negedge clk);
    chk("R6", "stack pointer 2", core_sp, 32'h1FFF_8000);
    chk("R6", "program counter 2", core_pc, 32'h0000_1235);

    // Scenario 3: programming boot
    opt_lpboot = 1'b0; prog_cs_n = 1'b0; ext_rst_n = 1'b0;
    cyc(25);
    ext_rst_n = 1'b1;
    while (sys_rst) @(negedge clk);
    reqs = 0;
    for (int i = 0; i < 12; i++) begin
      if (vec_req_valid || core_run) reqs++;
      @(negedge clk);
    end
    chk("R12", "no fetch or run in programming boot", reqs, 0);
    chk("R12", "programming active", prog_active, 1'b1);
    chk("R3", "programming mode latched", prog_mode, 1'b1);
    prog_cs_n = 1'b1; cyc(6);
    chk("R3", "strap release ignored", prog_mode, 1'b1);

    // Scenario 4: disable option overrides strap
    opt_prog_dis = 1'b1; prog_cs_n = 1'b0; ext_rst_n = 1'b0;
    cyc(25);
    ext_rst_n = 1'b1;
    while (!core_run) @(negedge clk);
    chk("R4", "disable forces normal boot", prog_mode, 1'b0);
    chk("R4", "no programming active", prog_active, 1'b0);

    // Scenario 5: pin asserted during the vector fetch
    opt_prog_dis = 1'b0; prog_cs_n = 1'b1;
    sp_word = 32'h2000_4000; pc_word = 32'h0000_0A01;
    ext_rst_n = 1'b0; cyc(5); ext_rst_n = 1'b1;
    while (!vec_req_valid) @(negedge clk);
    ext_rst_n = 1'b0; cyc(5);
    chk("R11", "no run after aborted fetch", core_run, 1'b0);
    chk("R10", "reset re-entered", sys_rst, 1'b1);
    ext_rst_n = 1'b1;
    while (!core_run) @(negedge clk);
    chk("R6", "stack pointer after abort", core_sp, 32'h2000_4000);
    chk("R6", "program counter after abort", core_pc, 32'h0000_0A01);
    cyc(3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule